// File: doc/BRIEF.md
# Two-Channel Interleaved MASH 1-1 Modulator

This block is the digital core of an oversampled delta-sigma DAC. It takes a high-resolution signed sample stream and reduces it to a 4-bit code stream for an array of 15 equal current cells. The logic runs at half the output sample rate. On every clock it takes one even and one odd consecutive sample and returns one code for each. A downstream 2:1 multiplexer, driven by the same clock, serializes the pair.

The noise shaping comes from two cascaded first-order error-feedback stages. Each stage adds its input to a residue of `FRAC_W` bits. The upper part of the sum is the stage output and the low `FRAC_W` bits become the new residue. The second stage takes the first stage's new residue as its input. The first difference of its carry is added to the first stage's output, which cancels the first stage's quantization error to first order.

The odd-sample update does not wait for the even-sample update. The odd residue is formed straight from the registered residue plus both current inputs. The odd quantizer output is the integer part of that double sum minus the even quantizer output. Each final code is offset to the unsigned range, clamped, and also presented as a 15-bit thermometer word.

Top module: `mash11_ilv`

## Requirements
- R1: A synchronous active-high `rst` clears both residues, the stored second-stage carry, `out_valid`, both codes and both thermometer words to zero.
- R2: `out_valid` equals the value `in_valid` had one clock earlier (latency of one register).
- R3: For a valid pair, `code_even` equals the code that a serial one-sample-per-step MASH 1-1 model gives for `in_even`. In that model, with L = `FRAC_W`: s1 = r1 + x, y1 = floor(s1 / 2^L), r1 = s1 mod 2^L; then s2 = r2 + r1, c2 = floor(s2 / 2^L), r2 = s2 mod 2^L; and y = y1 + c2 - c2_prev.
- R4: For a valid pair, `code_odd` equals the serial model's code for `in_odd` applied right after `in_even`. The look-ahead odd residue satisfies r_odd = (r_even + x_odd) mod 2^L.
- R5: The second-stage difference for the even sample subtracts the carry of the odd sample of the most recent earlier valid pair. The second-stage carry is always 0 or 1.
- R6: The code is y + 2^(OUT_W-1), clamped to 0 at the low end and to 2^OUT_W - 1 at the high end.
- R7: Bit i of each thermometer word is 1 exactly when i is less than the matching code, so its count of ones equals the code.
- R8: A cycle with `in_valid` low changes no residue and no stored carry, and leaves both codes and thermometer words at their previous values.
- R9: Inputs are two's-complement signed. Over 64 valid pairs of a constant input x, the sum of (code - 2^(OUT_W-1)) is within 2 of 128·x / 2^FRAC_W, as long as no code clamps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock shared by both channels |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The input pair is valid this cycle |
| in_even | input | IN_W | Earlier sample of the pair, signed |
| in_odd | input | IN_W | Later sample of the pair, signed |
| out_valid | output | 1 | The output pair is valid |
| code_even | output | OUT_W | Unsigned cell count for the earlier sample |
| code_odd | output | OUT_W | Unsigned cell count for the later sample |
| therm_even | output | 2^OUT_W-1 | Thermometer word for the earlier sample |
| therm_odd | output | 2^OUT_W-1 | Thermometer word for the later sample |

## Verification
Every code is compared sample by sample with a serial model that updates one sample at a time. If the look-ahead odd quotient were taken from the double sum without subtracting the even quotient, every odd code would come out large. If the even sample's carry difference used the wrong earlier carry, the noise would no longer cancel and the codes would drift off the model. Runs at full-scale positive and negative input drive the offset code past both ends, so a missing or misplaced clamp would wrap to the far end. Idle cycles placed between valid pairs expose a design that advances its residues or its outputs while `in_valid` is low. A constant-input run checks that the average of the codes tracks the input, which a wrong residue width or offset would break.

// File: rtl/mash_pkg.sv
package mash_pkg;

    // Clamp a signed integer into 0..hi.
    function automatic int clamp_code(int v, int hi);
        if (v < 0) begin
            return 0;
        end
        if (v > hi) begin
            return hi;
        end
        return v;
    endfunction

endpackage

// File: rtl/mash_la_stage.sv
// One first-order error-feedback stage evaluated for two samples per clock.
// The odd-sample values come from the registered residue plus both inputs,
// not from the even-sample result.
module mash_la_stage #(
    parameter int X_W = 12,
    parameter int L   = 8
) (
    input  logic [L-1:0]           r_prev,
    input  logic signed [X_W-1:0]  x_even,
    input  logic signed [X_W-1:0]  x_odd,
    output logic signed [X_W+1-L:0] q_even,
    output logic signed [X_W+1-L:0] q_odd,
    output logic [L-1:0]           r_even,
    output logic [L-1:0]           r_odd
);
    localparam int SW = X_W + 2;
    localparam int QW = SW - L;

    logic signed [SW-1:0] rp_s, xe_s, xo_s, sum_e, sum_o;
    logic signed [QW-1:0] q_tot;

    always_comb begin
        rp_s   = $signed({{(SW-L){1'b0}}, r_prev});
        xe_s   = $signed({{2{x_even[X_W-1]}}, x_even});
        xo_s   = $signed({{2{x_odd[X_W-1]}}, x_odd});
        sum_e  = rp_s + xe_s;
        sum_o  = rp_s + xe_s + xo_s;
        q_even = $signed(sum_e[SW-1:L]);
        q_tot  = $signed(sum_o[SW-1:L]);
        q_odd  = q_tot - q_even;
        r_even = sum_e[L-1:0];
        r_odd  = sum_o[L-1:0];
    end

endmodule

// File: rtl/mash_therm.sv
// Code to thermometer word: bit i set when i < code.
module mash_therm #(
    parameter int OUT_W = 4,
    parameter int CELLS = 15
) (
    input  logic [OUT_W-1:0] code,
    output logic [CELLS-1:0] therm
);
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        assign therm[i] = (code > OUT_W'(i));
    end
endmodule

// File: rtl/mash11_ilv.sv
module mash11_ilv #(
    parameter int IN_W   = 12,
    parameter int FRAC_W = 8,
    parameter int OUT_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_even,
    input  logic signed [IN_W-1:0]  in_odd,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        code_even,
    output logic [OUT_W-1:0]        code_odd,
    output logic [2**OUT_W-2:0]     therm_even,
    output logic [2**OUT_W-2:0]     therm_odd
);
    localparam int CELLS  = 2**OUT_W - 1;
    localparam int OFFSET = 2**(OUT_W-1);
    localparam int Q1W    = IN_W + 2 - FRAC_W;
    localparam int Q2W    = 3;
    localparam int YW     = Q1W + 2;

    typedef struct packed {
        logic [FRAC_W-1:0]     r1;
        logic [FRAC_W-1:0]     r2;
        logic signed [Q2W-1:0] c2_last;
        logic                  vld;
        logic [OUT_W-1:0]      code_e;
        logic [OUT_W-1:0]      code_o;
    } state_t;

    state_t st_d, st_q;

    logic signed [Q1W-1:0]  q1e, q1o;
    logic [FRAC_W-1:0]      r1e, r1o, r2e, r2o;
    logic signed [Q2W-1:0]  c2e, c2o;
    logic signed [FRAC_W:0] s2_xe, s2_xo;
    logic signed [YW-1:0]   y_e, y_o;
    logic [FRAC_W-1:0]      lk_chk;
    int                     ye_i, yo_i;

    // First stage: signed samples in.
    mash_la_stage #(.X_W(IN_W), .L(FRAC_W)) u_st1 (
        .r_prev (st_q.r1),
        .x_even (in_even),
        .x_odd  (in_odd),
        .q_even (q1e),
        .q_odd  (q1o),
        .r_even (r1e),
        .r_odd  (r1o)
    );

    assign s2_xe = $signed({1'b0, r1e});
    assign s2_xo = $signed({1'b0, r1o});

    // Second stage: first-stage residues in, carries out.
    mash_la_stage #(.X_W(FRAC_W + 1), .L(FRAC_W)) u_st2 (
        .r_prev (st_q.r2),
        .x_even (s2_xe),
        .x_odd  (s2_xo),
        .q_even (c2e),
        .q_odd  (c2o),
        .r_even (r2e),
        .r_odd  (r2o)
    );

    always_comb begin
        y_e = $signed({{2{q1e[Q1W-1]}}, q1e})
            + $signed({{(YW-Q2W){c2e[Q2W-1]}}, c2e})
            - $signed({{(YW-Q2W){st_q.c2_last[Q2W-1]}}, st_q.c2_last});
        y_o = $signed({{2{q1o[Q1W-1]}}, q1o})
            + $signed({{(YW-Q2W){c2o[Q2W-1]}}, c2o})
            - $signed({{(YW-Q2W){c2e[Q2W-1]}}, c2e});
        ye_i = int'(y_e);
        yo_i = int'(y_o);

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.r1      = r1o;
            st_d.r2      = r2o;
            st_d.c2_last = c2o;
            st_d.code_e  = OUT_W'(mash_pkg::clamp_code(ye_i + OFFSET, CELLS));
            st_d.code_o  = OUT_W'(mash_pkg::clamp_code(yo_i + OFFSET, CELLS));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign code_even = st_q.code_e;
    assign code_odd  = st_q.code_o;

    mash_therm #(.OUT_W(OUT_W), .CELLS(CELLS)) u_th_e (
        .code  (st_q.code_e),
        .therm (therm_even)
    );
    mash_therm #(.OUT_W(OUT_W), .CELLS(CELLS)) u_th_o (
        .code  (st_q.code_o),
        .therm (therm_odd)
    );

    // Serial chaining of the residue, used to cross-check the look-ahead.
    assign lk_chk = r1e + in_odd[FRAC_W-1:0];

    // R2: the valid flag follows the input flag by one cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R4: the look-ahead odd residue equals the chained serial update
    a_r4_lookahead: assert property (@(posedge clk) disable iff (rst)
        lk_chk == r1o);
    // R5: the second-stage carry is a single bit
    a_r5_carry_range: assert property (@(posedge clk) disable iff (rst)
        (c2e == 0 || c2e == 1) && (c2o == 0 || c2o == 1));
    // R7: the thermometer count matches the code and the ones are contiguous
    a_r7_therm_count: assert property (@(posedge clk) disable iff (rst)
        $countones(therm_even) == int'(code_even) &&
        $countones(therm_odd) == int'(code_odd));
    a_r7_therm_shape: assert property (@(posedge clk) disable iff (rst)
        ((therm_even & (therm_even + CELLS'(1))) == '0) &&
        ((therm_odd & (therm_odd + CELLS'(1))) == '0));
    // R8: an idle cycle leaves the codes unchanged
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(code_even) && $stable(code_odd));

endmodule

// File: tb/mash11_ilv_bench.sv
module mash11_ilv_bench;
    localparam int IN_W   = 12;
    localparam int FRAC_W = 8;
    localparam int OUT_W  = 4;
    localparam int CELLS  = 15;
    localparam int OFFSET = 8;
    localparam int MASK   = (1 << FRAC_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [IN_W-1:0] in_even = '0;
    logic signed [IN_W-1:0] in_odd = '0;
    logic out_valid;
    logic [OUT_W-1:0] code_even, code_odd;
    logic [CELLS-1:0] therm_even, therm_odd;

    mash11_ilv #(.IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_mash11_ilv (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_even(in_even), .in_odd(in_odd),
        .out_valid(out_valid), .code_even(code_even), .code_odd(code_odd),
        .therm_even(therm_even), .therm_odd(therm_odd)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Serial reference state
    int m_r1 = 0, m_r2 = 0, m_c2p = 0;
    int exp_e = 0, exp_o = 0;
    int last_raw_e = 0, last_raw_o = 0;

    function automatic int model_step(int x);
        int s1, y1, s2, c2, y;
        s1    = m_r1 + x;
        y1    = s1 >>> FRAC_W;
        m_r1  = s1 & MASK;
        s2    = m_r2 + m_r1;
        c2    = s2 >>> FRAC_W;
        m_r2  = s2 & MASK;
        y     = y1 + c2 - m_c2p;
        m_c2p = c2;
        return y;
    endfunction

    function automatic int clamp(int v);
        if (v < 0) return 0;
        if (v > CELLS) return CELLS;
        return v;
    endfunction

    task automatic check(string tag, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic model_reset();
        m_r1 = 0; m_r2 = 0; m_c2p = 0; exp_e = 0; exp_o = 0;
    endtask

    // Drive one pair at a falling edge, check one clock later at a falling edge.
    task automatic step(bit v, int xe, int xo);
        string te, to;
        int prev_c2;
        in_valid = v;
        in_even  = IN_W'(xe);
        in_odd   = IN_W'(xo);
        te = "R8"; to = "R8";
        if (v) begin
            prev_c2    = m_c2p;
            last_raw_e = model_step(xe);
            last_raw_o = model_step(xo);
            exp_e = clamp(last_raw_e + OFFSET);
            exp_o = clamp(last_raw_o + OFFSET);
            te = (prev_c2 != 0) ? "R5" : "R3";
            to = "R4";
            if (last_raw_e + OFFSET < 0 || last_raw_e + OFFSET > CELLS) te = "R6";
            if (last_raw_o + OFFSET < 0 || last_raw_o + OFFSET > CELLS) to = "R6";
        end
        @(posedge clk);
        @(negedge clk);
        check("R2 out_valid", int'(out_valid), int'(v));
        check({te, " code_even"}, int'(code_even), exp_e);
        check({to, " code_odd"}, int'(code_odd), exp_o);
        check("R7 therm_even", int'(therm_even), (1 << exp_e) - 1);
        check("R7 therm_odd", int'(therm_odd), (1 << exp_o) - 1);
    endtask

    task automatic check_reset_state();
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 code_even", int'(code_even), 0);
        check("R1 code_odd", int'(code_odd), 0);
        check("R1 therm_even", int'(therm_even), 0);
        check("R1 therm_odd", int'(therm_odd), 0);
    endtask

    task automatic dc_run(int x);
        int acc = 0;
        int target;
        for (int i = 0; i < 64; i++) begin
            step(1'b1, x, x);
            acc += int'(code_even) - OFFSET + int'(code_odd) - OFFSET;
        end
        target = (128 * x) / (1 << FRAC_W);
        n_cmp++;
        if (acc - target > 2 || target - acc > 2) begin
            n_bad++;
            $display("FAIL R9 dc sum actual=%0d expected=%0d (+/-2)", acc, target);
        end
    endtask

    function automatic int rnd_sample();
        return int'($urandom_range(0, 4095)) - 2048;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        model_reset();

        // Directed: zeros, idle gaps, full scale both ways, alternating extremes
        for (int i = 0; i < 8; i++) step(1'b1, 0, 0);
        step(1'b0, 1234, -999);
        step(1'b0, -2048, 2047);
        for (int i = 0; i < 12; i++) step(1'b1, 2047, 2047);
        for (int i = 0; i < 12; i++) step(1'b1, -2048, -2048);
        for (int i = 0; i < 12; i++) step(1'b1, 2047, -2048);
        for (int i = 0; i < 6; i++) step(1'b1, 129, 127);
        step(1'b0, 5, 5);
        for (int i = 0; i < 6; i++) step(1'b1, -1, 1);

        // Constrained random with idle cycles about one in five
        for (int i = 0; i < 1500; i++) begin
            bit v = ($urandom_range(0, 4) != 0);
            step(v, rnd_sample(), rnd_sample());
        end

        // Reset in the middle of traffic
        in_valid = 1'b1;
        in_even  = IN_W'(700);
        in_odd   = IN_W'(-300);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        model_reset();
        for (int i = 0; i < 20; i++) step(1'b1, rnd_sample(), rnd_sample());

        // Average tracking
        dc_run(512);
        dc_run(-768);
        dc_run(100);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(64'd4_000_000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule